// File: doc/BRIEF.md
# Load-Compensated Half-Bridge Oscillator

This block produces the two gate-enable signals of a half-bridge power stage. A digital load level of eight bits stands in for the filtered current-sense voltage. The block turns that level into a half-period length in system clocks. A heavier load gives a longer period and so a lower switching frequency. A lighter load raises the frequency, and the delivered output voltage then drops without any feedback from the output. A defined code range sets the end points: code 0 gives the highest frequency (about 70 kHz by default) and code 255 gives the lowest (about 34 kHz).

An internal triangle generator adds a small dither to the load code. It runs at twice the line frequency, with the line frequency set by a parameter, and it spreads the switching spectrum over several kHz. When the protection logic has taken the timing capacitor for fault timing, it raises `force_min`, and the oscillator then runs at its lowest frequency. When the protection logic drops `run_en`, both outputs go low.

Each half-period starts with a fixed dead time in which both outputs are low. A new period value is taken only when a full cycle begins, so a half-cycle is never cut short.

Top module: `lcomp_hb_osc`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released with `run_en` low, both `hs_drv` and `ls_drv` are 0.
- R2: `hs_drv` and `ls_drv` are never 1 in the same cycle. Before either output rises, both outputs have been low for at least DEAD_CLKS consecutive cycles.
- R3: A cycle lasts 2·H clocks, counted as cycle positions 0..2H−1. `hs_drv` is 1 at positions DEAD_CLKS..H−1 and `ls_drv` is 1 at positions H+DEAD_CLKS..2H−1. H = HALF_MIN + ((HALF_MAX−HALF_MIN)·(c + c[7])) >> 8, where c is the effective code sampled at position 0, HALF_MIN = CLK_HZ/(2·F_HI_HZ) and HALF_MAX = CLK_HZ/(2·F_LO_HZ).
- R4: A higher load code never gives a shorter period. Code 0 gives H = HALF_MIN and code 255 gives H = HALF_MAX.
- R5: The effective code is load + t − DITHER_AMP, where t is a triangle. After reset t is 0 and rising. t moves by one every STEP clocks and turns around at 2·DITHER_AMP and at 0. STEP = max(1, CLK_HZ/(8·LINE_HZ·DITHER_AMP)).
- R6: While `force_min` is 1, the effective code is 255 whatever the load and the dither.
- R7: A change of `load_code` or `force_min` during a cycle does not alter that cycle. It takes effect from the next position 0.
- R8: While `run_en` is 0, both outputs are 0 in that same cycle. On the first edge with `run_en` at 1, a new cycle begins at position 0.
- R9: The effective code saturates at 0 and at 255. It does not wrap when the dither pushes it past either end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_code | input | 8 | Load level, 0 = no load, 255 = full load |
| run_en | input | 1 | Run permission from the protection logic |
| force_min | input | 1 | Forces the lowest frequency during fault timing |
| hs_drv | output | 1 | High-side gate enable |
| ls_drv | output | 1 | Low-side gate enable |

## Verification
A wrong cycle counter or a wrong latched half-period moves an edge of `hs_drv` or `ls_drv`. That shift shows within one switching cycle, at the latest at the next position 0. A faulty triangle changes the period only once the dither has moved the code far enough to change H, so the bench runs for several triangle periods at mid-scale load, where every step of t shows. A bad clamp wraps the code at the ends. The wrapped code shows up at once as a period far too short at full load, or far too long at zero load.

// File: rtl/lcomp_osc_pkg.sv
package lcomp_osc_pkg;

   localparam int CODE_W   = 8;
   localparam int CODE_TOP = (1 << CODE_W) - 1;

   typedef logic [CODE_W-1:0] load_code_t;

   // Saturating conversion of a signed sum to a code value.
   function automatic load_code_t sat_code(input int signed v);
      if (v < 0)
         return '0;
      else if (v > CODE_TOP)
         return load_code_t'(CODE_TOP);
      else
         return load_code_t'(v);
   endfunction

endpackage

// File: rtl/lcomp_dither_tri.sv
module lcomp_dither_tri #(
   parameter int AMP    = 12,
   parameter int STEP   = 1,
   parameter bit EN     = 1'b1,
   localparam int TRI_W = $clog2(2*AMP+1)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TRI_W-1:0] tri_o
);

   generate
      if (EN) begin : g_tri
         localparam int SW = (STEP > 1) ? $clog2(STEP) : 1;
         localparam logic [TRI_W-1:0] PEAK = TRI_W'(2*AMP);

         logic [SW-1:0]    step_q;
         logic [TRI_W-1:0] pos_q;
         logic             up_q;
         logic             tick;

         assign tick = (step_q == SW'(STEP-1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               step_q <= '0;
               pos_q  <= '0;
               up_q   <= 1'b1;
            end else if (tick) begin
               step_q <= '0;
               if (up_q) begin
                  pos_q <= pos_q + 1'b1;
                  if (pos_q + 1'b1 == PEAK) up_q <= 1'b0;
               end else begin
                  pos_q <= pos_q - 1'b1;
                  if (pos_q - 1'b1 == '0) up_q <= 1'b1;
               end
            end else begin
               step_q <= step_q + 1'b1;
            end
         end

         assign tri_o = pos_q;
      end else begin : g_flat
         // Midpoint value cancels the offset, so there is no dither.
         assign tri_o = TRI_W'(AMP);
      end
   endgenerate

endmodule

// File: rtl/lcomp_code_sel.sv
module lcomp_code_sel
   import lcomp_osc_pkg::*;
#(
   parameter int AMP    = 12,
   localparam int TRI_W = $clog2(2*AMP+1)
) (
   input  load_code_t       load_i,
   input  logic [TRI_W-1:0] tri_i,
   input  logic             force_min_i,
   output load_code_t       code_o
);

   int signed sum;

   always_comb begin
      sum = int'({1'b0, load_i}) + int'({1'b0, tri_i}) - AMP;
      if (force_min_i)
         code_o = load_code_t'(CODE_TOP);
      else
         code_o = sat_code(sum);
   end

endmodule

// File: rtl/lcomp_period_map.sv
module lcomp_period_map
   import lcomp_osc_pkg::*;
#(
   parameter int HALF_MIN = 357,
   parameter int HALF_MAX = 735,
   parameter int HW       = 11
) (
   input  load_code_t    code_i,
   output logic [HW-1:0] half_o
);

   localparam int SPAN = HALF_MAX - HALF_MIN;
   localparam int PW   = HW + CODE_W + 1;

   logic [CODE_W:0] wgt;
   logic [PW-1:0]   prod;

   // The weight runs 0..256, so the top code lands exactly on HALF_MAX.
   assign wgt    = {1'b0, code_i} + {{CODE_W{1'b0}}, code_i[CODE_W-1]};
   assign prod   = PW'(SPAN) * PW'(wgt);
   assign half_o = HW'(HALF_MIN) + HW'(prod >> CODE_W);

endmodule

// File: rtl/lcomp_hb_timer.sv
module lcomp_hb_timer #(
   parameter int DEAD = 16,
   parameter int HW   = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   input  logic [HW-1:0] half_next,
   output logic          hs_o,
   output logic          ls_o
);

   localparam logic [HW-1:0] DEAD_V = HW'(DEAD);

   logic          running_q;
   logic [HW-1:0] cnt_q;
   logic [HW-1:0] half_q;
   logic [HW:0]   last_pos;
   logic          at_end;

   assign last_pos = {half_q, 1'b0} - 1'b1;
   assign at_end   = ({1'b0, cnt_q} == last_pos);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         cnt_q     <= '0;
         half_q    <= '0;
      end else if (!run_en) begin
         running_q <= 1'b0;
         cnt_q     <= '0;
      end else if (!running_q || at_end) begin
         running_q <= 1'b1;
         cnt_q     <= '0;
         half_q    <= half_next;
      end else begin
         cnt_q     <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      hs_o = run_en && running_q && (cnt_q >= DEAD_V) && (cnt_q < half_q);
      ls_o = run_en && running_q && ({1'b0, cnt_q} >= {1'b0, half_q} + {1'b0, DEAD_V});
   end

endmodule

// File: rtl/lcomp_hb_osc.sv
module lcomp_hb_osc
   import lcomp_osc_pkg::*;
#(
   parameter int CLK_HZ     = 50_000_000,
   parameter int F_HI_HZ    = 70_000,
   parameter int F_LO_HZ    = 34_000,
   parameter int LINE_HZ    = 50,
   parameter int DITHER_AMP = 12,
   parameter bit DITHER_EN  = 1'b1,
   parameter int DEAD_CLKS  = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] load_code,
   input  logic       run_en,
   input  logic       force_min,
   output logic       hs_drv,
   output logic       ls_drv
);

   localparam int HALF_MIN = CLK_HZ / (2*F_HI_HZ);
   localparam int HALF_MAX = CLK_HZ / (2*F_LO_HZ);
   localparam int HW       = $clog2(2*HALF_MAX+1);
   localparam int AMP_SAFE = (DITHER_AMP < 1) ? 1 : DITHER_AMP;
   localparam int STEP_RAW = CLK_HZ / (8*LINE_HZ*AMP_SAFE);
   localparam int STEP     = (STEP_RAW < 1) ? 1 : STEP_RAW;
   localparam int TRI_W    = $clog2(2*DITHER_AMP+1);

   generate
      if (F_HI_HZ <= F_LO_HZ) begin : g_bad_freq
         $error("F_HI_HZ must exceed F_LO_HZ");
      end
      if (DEAD_CLKS < 1 || DEAD_CLKS >= HALF_MIN) begin : g_bad_dead
         $error("DEAD_CLKS must lie in 1..HALF_MIN-1");
      end
      if (DITHER_AMP < 1 || DITHER_AMP > 64) begin : g_bad_amp
         $error("DITHER_AMP must lie in 1..64");
      end
      if (LINE_HZ < 1) begin : g_bad_line
         $error("LINE_HZ must be positive");
      end
   endgenerate

   logic [TRI_W-1:0] tri_val;
   load_code_t       eff_code;
   logic [HW-1:0]    half_next;

   lcomp_dither_tri #(
      .AMP  (DITHER_AMP),
      .STEP (STEP),
      .EN   (DITHER_EN)
   ) u_tri (
      .clk   (clk),
      .rst_n (rst_n),
      .tri_o (tri_val)
   );

   lcomp_code_sel #(
      .AMP (DITHER_AMP)
   ) u_sel (
      .load_i      (load_code),
      .tri_i       (tri_val),
      .force_min_i (force_min),
      .code_o      (eff_code)
   );

   lcomp_period_map #(
      .HALF_MIN (HALF_MIN),
      .HALF_MAX (HALF_MAX),
      .HW       (HW)
   ) u_map (
      .code_i (eff_code),
      .half_o (half_next)
   );

   lcomp_hb_timer #(
      .DEAD (DEAD_CLKS),
      .HW   (HW)
   ) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .half_next (half_next),
      .hs_o      (hs_drv),
      .ls_o      (ls_drv)
   );

endmodule

// File: rtl/lcomp_hb_osc_chk.sv
module lcomp_hb_osc_chk #(
   parameter int DEAD_CLKS = 16,
   parameter int HALF_MAX  = 735
) (
   input logic clk,
   input logic rst_n,
   input logic run_en,
   input logic hs_drv,
   input logic ls_drv
);

   localparam int GW = $clog2(DEAD_CLKS+1);
   localparam int WW = $clog2(HALF_MAX+1);

   logic [GW-1:0] gap_q;
   logic [WW-1:0] hs_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q    <= GW'(DEAD_CLKS);
         hs_run_q <= '0;
      end else begin
         if (hs_drv || ls_drv)
            gap_q <= '0;
         else if (gap_q < GW'(DEAD_CLKS))
            gap_q <= gap_q + 1'b1;
         hs_run_q <= hs_drv ? hs_run_q + 1'b1 : '0;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_QUIET_IN_RESET: assert (!hs_drv && !ls_drv); // R1
      end
   end

   AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_drv && ls_drv)); // R2

   AST_DEAD_BEFORE_HS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_drv) |-> (gap_q >= GW'(DEAD_CLKS))); // R2

   AST_DEAD_BEFORE_LS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_drv) |-> (gap_q >= GW'(DEAD_CLKS))); // R2

   AST_OFF_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |-> (!hs_drv && !ls_drv)); // R8

   AST_HS_WIDTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      hs_drv |-> (hs_run_q < WW'(HALF_MAX - DEAD_CLKS))); // R4

endmodule

bind lcomp_hb_osc lcomp_hb_osc_chk #(
   .DEAD_CLKS (DEAD_CLKS),
   .HALF_MAX  (HALF_MAX)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .run_en (run_en),
   .hs_drv (hs_drv),
   .ls_drv (ls_drv)
);

// File: tb/lcomp_hb_osc_bench.sv
`timescale 1ns/1ps
module lcomp_hb_osc_bench;

   localparam int P_CLK  = 2_000_000;
   localparam int P_FHI  = 70_000;
   localparam int P_FLO  = 34_000;
   localparam int P_LINE = 2_000;
   localparam int P_AMP  = 8;
   localparam int P_DEAD = 3;

   // Expected constants worked out from the requirements.
   localparam int E_HMIN = 14;
   localparam int E_HMAX = 29;
   localparam int E_STEP = 15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] load_code = 8'd0;
   logic       run_en = 1'b0;
   logic       force_min = 1'b0;
   logic       hs_drv, ls_drv;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   lcomp_hb_osc #(
      .CLK_HZ     (P_CLK),
      .F_HI_HZ    (P_FHI),
      .F_LO_HZ    (P_FLO),
      .LINE_HZ    (P_LINE),
      .DITHER_AMP (P_AMP),
      .DITHER_EN  (1'b1),
      .DEAD_CLKS  (P_DEAD)
   ) u_lcomp_hb_osc (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_code (load_code),
      .run_en    (run_en),
      .force_min (force_min),
      .hs_drv    (hs_drv),
      .ls_drv    (ls_drv)
   );

   // Behavioural reference model
   int m_run, m_pos, m_half;
   int t_val, t_up, t_div;

   function automatic int exp_half(input int c);
      int w;
      w = c + ((c >= 128) ? 1 : 0);
      return E_HMIN + ((E_HMAX - E_HMIN) * w) / 256;
   endfunction

   function automatic int exp_code(input int ld, input int tv, input bit fm);
      int s;
      if (fm) return 255;
      s = ld + tv - P_AMP;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      return s;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_pos = 0; m_half = 0;
         t_val = 0; t_up = 1; t_div = 0;
      end else begin
         int tgt;
         tgt = exp_half(exp_code(int'(load_code), t_val, force_min));
         if (!run_en) begin
            m_run = 0; m_pos = 0;
         end else if (m_run == 0 || m_pos == 2*m_half - 1) begin
            m_run = 1; m_pos = 0; m_half = tgt;
         end else begin
            m_pos++;
         end
         if (t_div == E_STEP - 1) begin
            t_div = 0;
            t_val += t_up ? 1 : -1;
            if (t_val == 2*P_AMP) t_up = 0;
            if (t_val == 0) t_up = 1;
         end else begin
            t_div++;
         end
      end
   end

   always @(negedge clk) begin
      #1;
      if (!done) begin
         bit e_hs, e_ls;
         e_hs = run_en && m_run != 0 && m_pos >= P_DEAD && m_pos < m_half;
         e_ls = run_en && m_run != 0 && m_pos >= m_half + P_DEAD;
         n_checks++;
         if (hs_drv !== e_hs || ls_drv !== e_ls) begin
            n_fail++;
            $display("FAIL %s t=%0t hs/ls actual %b%b expected %b%b",
                     cur_req, $time, hs_drv, ls_drv, e_hs, e_ls);
         end
      end
   end

   task automatic check(input string req, input bit ok, input int act, input int exp_v);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hs_width(output int w);
      w = 0;
      @(negedge clk); #1;
      while (hs_drv) begin @(negedge clk); #1; end
      while (!hs_drv) begin @(negedge clk); #1; end
      while (hs_drv) begin w++; @(negedge clk); #1; end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (150_000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual 1 expected 0");
         finish_run();
      end
   end

   initial begin
      int w;
      // R1: quiet during reset and afterwards while halted
      cur_req = "R1";
      idle(4);
      check("R1", hs_drv === 1'b0 && ls_drv === 1'b0, int'({hs_drv, ls_drv}), 0);
      rst_n = 1'b1;
      idle(3);
      check("R1", hs_drv === 1'b0 && ls_drv === 1'b0, int'({hs_drv, ls_drv}), 0);

      // R8: load changes while halted leave outputs low
      cur_req = "R8";
      load_code = 8'd200; idle(20);
      check("R8", hs_drv === 1'b0, int'(hs_drv), 0);

      // R4 / R9: zero load, dither clamps at 0, period at minimum
      cur_req = "R9";
      load_code = 8'd0; run_en = 1'b1;
      idle(400);
      cur_req = "R4";
      hs_width(w);
      check("R4", w == E_HMIN - P_DEAD, w, E_HMIN - P_DEAD);

      // R9: full load, dither clamps at 255
      cur_req = "R9";
      load_code = 8'd255;
      idle(600);
      hs_width(w);
      check("R9", w >= E_HMAX - P_DEAD - 1 && w <= E_HMAX - P_DEAD, w, E_HMAX - P_DEAD);

      // R3 / R5: mid-scale, the dither shows in every step
      cur_req = "R5";
      load_code = 8'd128;
      idle(1500);
      cur_req = "R3";
      load_code = 8'd77;
      idle(500);

      // R7: changes in mid-cycle
      cur_req = "R7";
      for (int i = 0; i < 40; i++) begin
         load_code = 8'((i * 53) & 8'hFF);
         force_min = (i % 7 == 3);
         idle(7 + (i % 11));
      end
      force_min = 1'b0;

      // R6: force_min overrides load and dither
      cur_req = "R6";
      load_code = 8'd0; force_min = 1'b1;
      idle(100);
      hs_width(w);
      check("R6", w == E_HMAX - P_DEAD, w, E_HMAX - P_DEAD);
      idle(300);
      force_min = 1'b0;

      // R8: halt and resume in mid-cycle
      cur_req = "R8";
      for (int i = 0; i < 6; i++) begin
         idle(13 + 5*i);
         run_en = 1'b0;
         #2;
         check("R8", hs_drv === 1'b0 && ls_drv === 1'b0, int'({hs_drv, ls_drv}), 0);
         idle(3 + i);
         run_en = 1'b1;
      end

      // R2: long run covering all phases of the dither
      cur_req = "R2";
      load_code = 8'd180;
      idle(1200);

      finish_run();
   end

endmodule